// File: doc/BRIEF.md
# Descriptor Ring Transmit DMA Engine

This block moves outgoing data from system memory to a word-wide data stream under control of a ring of buffer descriptors that software keeps in memory. The CPU writes the ring's start address into a register, fills in descriptors, marks them as owned by hardware, and writes a start strobe. The engine then reads each descriptor through a single request/grant memory port. It streams the buffer the descriptor points at, and writes the descriptor's control word back with the ownership bit cleared, which returns the entry to software.

Descriptors sit back to back, 8 bytes apart. A wrap flag in a descriptor sends the engine back to the ring's start after that entry. When the engine reads a descriptor that software has not released, it stops at that entry and reports itself idle. The next start strobe fetches the same entry again. A descriptor that closes a frame sets a sticky completion flag, which also drives the interrupt line. Software clears the flag by writing one to it.

Top module: `dma_tx_ring`

## Requirements
- R1: After reset the engine is stopped. The status register reads idle=1 (bit 0) and done flag=0 (bit 1), the base register and the ring pointer read 0, and mem_req, tx_valid and irq are low.
- R2: A write to register 0 stores the ring base with bits 2:0 forced to zero. When the engine is stopped, the same write also loads the ring pointer (readable at register 3) with that value.
- R3: Writing 1 to bit 0 of register 1 while the engine is stopped starts it at the current ring pointer. Status bit 0 reads 0 on the next cycle.
- R4: A descriptor is two 32-bit words. Word 0 at the pointer is the buffer byte address. Word 1 at pointer+4 holds ownership in bit 31 (1 = hardware), wrap in bit 30, end-of-frame in bit 29 and the buffer length in bytes in bits 13:0. Word 0 is read before word 1.
- R5: A hardware-owned buffer of L bytes goes out as ceil(L/4) beats read from consecutive words starting at the buffer address. tx_keep is 4'hF on every beat except the last, which enables the low (L mod 4) bytes, or all four when L mod 4 is 0. A zero-length buffer produces no beats.
- R6: tx_last is high only on the final beat of a descriptor whose end-of-frame bit is set.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_keep and tx_last hold their values.
- R8: After the final beat of a descriptor has been accepted, the engine writes word 1 back to pointer+4 with bit 31 cleared and all other bits unchanged. It never writes back before that beat.
- R9: After a write-back the pointer moves to the base register when the wrap bit was set, and to pointer+8 otherwise.
- R10: A descriptor whose bit 31 is 0 stops the engine. The status idle bit is set, the pointer stays on that entry and nothing is written back. The next start fetches that entry again.
- R11: Writing back a descriptor with end-of-frame set raises status bit 1 and irq. Writing 1 to status bit 1 clears it, writing 0 leaves it, and a new completion in the same cycle wins over the clear.
- R12: A memory request holds mem_we, mem_addr and mem_wdata steady until mem_gnt. At most one read is in flight, and its data returns on a later mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 control, 2 status, 3 ring pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream beat valid |
| tx_ready | input | 1 | Downstream accepts the beat |
| tx_data | output | 32 | Stream data |
| tx_keep | output | 4 | Byte enables of the beat |
| tx_last | output | 1 | Last beat of a frame |
| irq | output | 1 | Sticky frame-completion interrupt |

## Verification
The ring is walked with buffer lengths of 0, 3, 4, 5, 6, 8 and 13 bytes. These lengths separate full-word tails from one-, two- and three-byte tails, and they expose an empty buffer. Frame-ending and non-ending descriptors are mixed, which shows that tx_last and the completion flag follow the descriptor's own end-of-frame bit. Rings are closed by a wrap entry and also stopped partway at a software-owned entry, so wrapping, stopping and resuming at the stalled descriptor are each seen on their own. One run uses a pseudo-random ready pattern with a stalling memory port, which checks that beats are held and that write-back waits for the last accepted beat.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned KEEP_W      = WORD_W / 8;
  localparam int unsigned KEEP_LG     = $clog2(KEEP_W);
  localparam int unsigned LEN_W       = 14;
  localparam int unsigned BEAT_W      = LEN_W + 1 - KEEP_LG;
  localparam int unsigned DESC_STRIDE = 8;
  localparam int unsigned ALIGN_LG    = $clog2(DESC_STRIDE);
  localparam int unsigned W1_OFFSET   = 4;
  localparam int unsigned OWN_BIT     = 31;
  localparam int unsigned WRAP_BIT    = 30;
  localparam int unsigned EOF_BIT     = 29;
  localparam int unsigned REG_AW      = 2;

  typedef struct packed {
    logic             own;
    logic             wrap;
    logic             eof;
    logic [LEN_W-1:0] len;
  } desc_ctl_t;

  typedef enum logic [3:0] {
    WS_IDLE, WS_HEAD_REQ, WS_HEAD_WAIT, WS_CTL_REQ, WS_CTL_WAIT,
    WS_BUF_REQ, WS_BUF_WAIT, WS_BEAT, WS_WB
  } walk_state_t;

  typedef enum logic [REG_AW-1:0] {
    RSEL_BASE = 2'd0, RSEL_CTRL = 2'd1, RSEL_STAT = 2'd2, RSEL_PTR = 2'd3
  } reg_sel_t;

  function automatic desc_ctl_t desc_decode(input logic [WORD_W-1:0] w);
    desc_ctl_t c;
    c.own  = w[OWN_BIT];
    c.wrap = w[WRAP_BIT];
    c.eof  = w[EOF_BIT];
    c.len  = w[LEN_W-1:0];
    return c;
  endfunction

  // number of word beats needed to carry len bytes
  function automatic logic [BEAT_W-1:0] beats_of(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] t;
    t = {1'b0, len} + (LEN_W+1)'(KEEP_W - 1);
    return BEAT_W'(t >> KEEP_LG);
  endfunction

  // byte enables of the final beat
  function automatic logic [KEEP_W-1:0] tail_keep(input logic [LEN_W-1:0] len);
    logic [KEEP_LG-1:0] rem;
    logic [KEEP_W-1:0]  k;
    rem = len[KEEP_LG-1:0];
    for (int i = 0; i < KEEP_W; i++) k[i] = (rem == '0) || (i < int'(rem));
    return k;
  endfunction

  function automatic logic [WORD_W-1:0] next_ring_ptr(input logic [WORD_W-1:0] ptr,
                                                      input logic [WORD_W-1:0] base,
                                                      input logic wrap);
    return wrap ? base : ptr + WORD_W'(DESC_STRIDE);
  endfunction

  function automatic logic [WORD_W-1:0] align_desc(input logic [WORD_W-1:0] a);
    return {a[WORD_W-1:ALIGN_LG], ALIGN_LG'(0)};
  endfunction

endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [WORD_W-1:0] ring_ptr,
  input  logic              stop_evt,
  input  logic              frame_done_evt,
  output logic [WORD_W-1:0] base_addr,
  output logic [WORD_W-1:0] load_addr,
  output logic              base_load,
  output logic              go,
  output logic              eng_idle,
  output logic              done_flag
);

  logic wr_base, wr_ctrl, wr_stat;
  logic unused_wbit;

  assign wr_base   = reg_wr && (reg_sel_t'(reg_addr) == RSEL_BASE);
  assign wr_ctrl   = reg_wr && (reg_sel_t'(reg_addr) == RSEL_CTRL);
  assign wr_stat   = reg_wr && (reg_sel_t'(reg_addr) == RSEL_STAT);
  assign load_addr = align_desc(reg_wdata);
  assign base_load = wr_base && eng_idle;
  assign go        = wr_ctrl && reg_wdata[0] && eng_idle;
  assign unused_wbit = reg_wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      eng_idle  <= 1'b1;
      done_flag <= 1'b0;
    end else begin
      if (wr_base) base_addr <= load_addr;
      if (go) eng_idle <= 1'b0;
      else if (stop_evt) eng_idle <= 1'b1;
      if (frame_done_evt) done_flag <= 1'b1;
      else if (wr_stat && reg_wdata[1]) done_flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel_t'(reg_addr))
      RSEL_BASE: reg_rdata = base_addr;
      RSEL_STAT: reg_rdata = {{(WORD_W-2){1'b0}}, done_flag, eng_idle};
      RSEL_PTR:  reg_rdata = ring_ptr;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr
  import dma_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [WORD_W-1:0] load_addr,
  input  logic [WORD_W-1:0] base_addr,
  input  logic              wb_done,
  input  logic              wb_wrap,
  output logic [WORD_W-1:0] ring_ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n) ring_ptr <= '0;
    else if (base_load) ring_ptr <= load_addr;
    else if (wb_done) ring_ptr <= next_ring_ptr(ring_ptr, base_addr, wb_wrap);
  end

endmodule

// File: rtl/dma_ring_walker.sv
module dma_ring_walker
  import dma_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] ring_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic [KEEP_W-1:0] tx_keep,
  output logic              tx_last,
  output logic              stop_evt,
  output logic              wb_done,
  output logic              wb_wrap,
  output logic              frame_done_evt
);

  walk_state_t       st, st_nx;
  logic [WORD_W-1:0] buf_addr;
  logic [WORD_W-1:0] ctl_raw;
  desc_ctl_t         ctl;
  desc_ctl_t         fetched;
  logic [BEAT_W-1:0] beats_left;
  logic              final_beat;

  assign fetched        = desc_decode(mem_rdata);
  assign final_beat     = (beats_left == BEAT_W'(1));
  assign tx_valid       = (st == WS_BEAT);
  assign wb_wrap        = ctl.wrap;
  assign frame_done_evt = wb_done && ctl.eof;

  always_comb begin
    st_nx     = st;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ring_ptr;
    mem_wdata = '0;
    stop_evt  = 1'b0;
    wb_done   = 1'b0;
    case (st)
      WS_IDLE:      if (go) st_nx = WS_HEAD_REQ;
      WS_HEAD_REQ: begin
        mem_req = 1'b1;
        if (mem_gnt) st_nx = WS_HEAD_WAIT;
      end
      WS_HEAD_WAIT: if (mem_rvalid) st_nx = WS_CTL_REQ;
      WS_CTL_REQ: begin
        mem_req  = 1'b1;
        mem_addr = ring_ptr + WORD_W'(W1_OFFSET);
        if (mem_gnt) st_nx = WS_CTL_WAIT;
      end
      WS_CTL_WAIT: begin
        if (mem_rvalid) begin
          if (!fetched.own) begin
            stop_evt = 1'b1;
            st_nx    = WS_IDLE;
          end else if (beats_of(fetched.len) == '0) begin
            st_nx = WS_WB;
          end else begin
            st_nx = WS_BUF_REQ;
          end
        end
      end
      WS_BUF_REQ: begin
        mem_req  = 1'b1;
        mem_addr = buf_addr;
        if (mem_gnt) st_nx = WS_BUF_WAIT;
      end
      WS_BUF_WAIT:  if (mem_rvalid) st_nx = WS_BEAT;
      WS_BEAT: begin
        if (tx_ready) st_nx = final_beat ? WS_WB : WS_BUF_REQ;
      end
      WS_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ring_ptr + WORD_W'(W1_OFFSET);
        mem_wdata = ctl_raw & ~(WORD_W'(1) << OWN_BIT);
        if (mem_gnt) begin
          wb_done = 1'b1;
          st_nx   = WS_HEAD_REQ;
        end
      end
      default: st_nx = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= WS_IDLE;
      buf_addr   <= '0;
      ctl_raw    <= '0;
      ctl        <= '0;
      beats_left <= '0;
      tx_data    <= '0;
      tx_keep    <= '0;
      tx_last    <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == WS_HEAD_WAIT && mem_rvalid) buf_addr <= mem_rdata;
      if (st == WS_CTL_WAIT && mem_rvalid) begin
        ctl_raw    <= mem_rdata;
        ctl        <= fetched;
        beats_left <= beats_of(fetched.len);
      end
      if (st == WS_BUF_WAIT && mem_rvalid) begin
        tx_data <= mem_rdata;
        tx_keep <= final_beat ? tail_keep(ctl.len) : '1;
        tx_last <= final_beat && ctl.eof;
      end
      if (st == WS_BEAT && tx_ready) begin
        beats_left <= beats_left - BEAT_W'(1);
        buf_addr   <= buf_addr + WORD_W'(KEEP_W);
      end
    end
  end

endmodule

// File: rtl/dma_tx_ring.sv
module dma_tx_ring
  import dma_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic [KEEP_W-1:0] tx_keep,
  output logic              tx_last,
  output logic              irq
);

  logic [WORD_W-1:0] ring_ptr;
  logic [WORD_W-1:0] base_addr;
  logic [WORD_W-1:0] load_addr;
  logic              base_load;
  logic              go;
  logic              eng_idle;
  logic              done_flag;
  logic              stop_evt;
  logic              wb_done;
  logic              wb_wrap;
  logic              frame_done_evt;

  assign irq = done_flag;

  dma_ring_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ring_ptr(ring_ptr), .stop_evt(stop_evt), .frame_done_evt(frame_done_evt),
    .base_addr(base_addr), .load_addr(load_addr), .base_load(base_load),
    .go(go), .eng_idle(eng_idle), .done_flag(done_flag)
  );

  dma_ring_ptr u_ptr (
    .clk(clk), .rst_n(rst_n),
    .base_load(base_load), .load_addr(load_addr), .base_addr(base_addr),
    .wb_done(wb_done), .wb_wrap(wb_wrap), .ring_ptr(ring_ptr)
  );

  dma_ring_walker u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .ring_ptr(ring_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_keep(tx_keep), .tx_last(tx_last),
    .stop_evt(stop_evt), .wb_done(wb_done), .wb_wrap(wb_wrap),
    .frame_done_evt(frame_done_evt)
  );

endmodule

// File: rtl/dma_tx_ring_chk.sv
module dma_tx_ring_chk
  import dma_ring_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stat_clear,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_gnt,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [WORD_W-1:0] tx_data,
  input logic [KEEP_W-1:0] tx_keep,
  input logic              tx_last,
  input logic              irq,
  input logic              eng_idle,
  input logic              stop_evt,
  input logic              wb_done,
  input logic              wb_wrap,
  input logic              frame_done_evt,
  input logic [WORD_W-1:0] ring_ptr,
  input logic [WORD_W-1:0] base_addr
);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_keep) && $stable(tx_last));

  assert_stop_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> eng_idle && !mem_req);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !mem_req && !tx_valid);

  assert_wb_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_BIT] && !tx_valid);

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_evt |=> irq);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clear && !frame_done_evt |=> !irq);

  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done && !wb_wrap |=> ring_ptr == $past(ring_ptr) + WORD_W'(DESC_STRIDE));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done && wb_wrap |=> ring_ptr == $past(base_addr));

endmodule

bind dma_tx_ring dma_tx_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .stat_clear(reg_wr && (reg_addr == 2'd2) && reg_wdata[1]),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_gnt(mem_gnt), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_keep(tx_keep), .tx_last(tx_last), .irq(irq), .eng_idle(eng_idle),
  .stop_evt(stop_evt), .wb_done(wb_done), .wb_wrap(wb_wrap),
  .frame_done_evt(frame_done_evt), .ring_ptr(ring_ptr), .base_addr(base_addr)
);

// File: tb/sim_dma_tx_ring.sv
module sim_dma_tx_ring;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [31:0] tx_data;
  logic [3:0]  tx_keep;
  logic        tx_last;
  logic        irq;

  dma_tx_ring u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_keep(tx_keep), .tx_last(tx_last), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // memory model, stream monitor, handshake monitor
  logic [31:0] mem [MEM_WORDS];
  logic [7:0]  lfsr = 8'h5A;
  logic        host_we = 1'b0;
  logic [31:0] host_addr = '0, host_data = '0;
  logic        bp_mode = 1'b0;
  int          beat_cnt = 0;
  int          wb_n = 0;
  int          hold_viol = 0;
  logic [31:0] got_data [64];
  logic [3:0]  got_keep [64];
  logic        got_last [64];
  logic [31:0] wb_addr [16];
  int          wb_beats [16];
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] pat(input int w);
    return 32'h5A00_0000 ^ (w * 32'h0001_0003);
  endfunction

  function automatic logic [31:0] mk_w1(input bit own, input bit wrap, input bit eof, input int len);
    return {own, wrap, eof, 15'b0, 14'(len)};
  endfunction

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= pat(i);
      mem_gnt <= 1'b0;
      mem_rvalid <= 1'b0;
      pend <= 1'b0;
    end else begin
      mem_gnt    <= mem_req && !mem_gnt && (lfsr[1:0] != 2'b00);
      mem_rvalid <= mem_req && mem_gnt && !mem_we;
      if (mem_req && mem_gnt && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
      if (mem_req && mem_gnt && mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wb_addr[wb_n % 16]  <= mem_addr;
        wb_beats[wb_n % 16] <= beat_cnt;
        wb_n <= wb_n + 1;
      end
      if (host_we) mem[host_addr[9:2]] <= host_data;
      if (tx_valid && tx_ready) begin
        got_data[beat_cnt % 64] <= tx_data;
        got_keep[beat_cnt % 64] <= tx_keep;
        got_last[beat_cnt % 64] <= tx_last;
        beat_cnt <= beat_cnt + 1;
      end
      if (pend && (!mem_req || mem_addr != pend_addr)) hold_viol <= hold_viol + 1;
      pend      <= mem_req && !mem_gnt;
      pend_addr <= mem_addr;
    end
  end

  always @(negedge clk) tx_ready <= !bp_mode || lfsr[2];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic host_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] b, input logic [31:0] w1);
    host_write(a, b);
    host_write(a + 4, w1);
  endtask

  task automatic start_and_wait();
    logic [31:0] s;
    reg_write(2'd1, 32'h1);
    reg_read(2'd2, s);
    check(s[0] == 1'b0, "R3 engine leaves idle after start", s, 32'h0);
    for (int n = 0; n < 5000; n++) begin
      reg_read(2'd2, s);
      if (s[0]) break;
    end
    check(s[0] == 1'b1, "R10 engine stops at released entry", s, 32'h1);
  endtask

  task automatic expect_buf(inout int idx, input logic [31:0] b, input int len, input bit eof, input string req);
    int rem = len;
    int w = 0;
    while (rem > 0) begin
      logic [3:0] ek = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
      logic       el = eof && (rem <= 4);
      check(got_data[idx % 64] == pat(int'(b[9:2]) + w), {req, " R4 data"}, got_data[idx % 64], pat(int'(b[9:2]) + w));
      check(got_keep[idx % 64] == ek, {req, " R5 keep"}, 32'(got_keep[idx % 64]), 32'(ek));
      check(got_last[idx % 64] == el, {req, " R6 last"}, 32'(got_last[idx % 64]), 32'(el));
      idx++; w++; rem -= 4;
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    reg_read(2'd2, v); check(v == 32'h1, "R1 status after reset", v, 32'h1);
    reg_read(2'd0, v); check(v == 32'h0, "R1 base after reset", v, 32'h0);
    reg_read(2'd3, v); check(v == 32'h0, "R1 pointer after reset", v, 32'h0);
    check(!mem_req && !tx_valid && !irq, "R1 outputs quiet", {29'b0, mem_req, tx_valid, irq}, 32'h0);
  endtask

  task automatic test_ring_wrap();
    logic [31:0] v;
    int b0, n0, idx;
    reg_write(2'd0, 32'h100);
    set_desc(32'h100, 32'h200, mk_w1(1, 0, 0, 8));
    set_desc(32'h108, 32'h240, mk_w1(1, 0, 1, 5));
    set_desc(32'h110, 32'h280, mk_w1(1, 1, 1, 4));
    b0 = beat_cnt; n0 = wb_n;
    start_and_wait();
    check(beat_cnt - b0 == 5, "R5 beat count of ring", 32'(beat_cnt - b0), 32'd5);
    idx = b0;
    expect_buf(idx, 32'h200, 8, 1'b0, "ring d0");
    expect_buf(idx, 32'h240, 5, 1'b1, "ring d1");
    expect_buf(idx, 32'h280, 4, 1'b1, "ring d2");
    check(wb_n - n0 == 3, "R8 three write-backs", 32'(wb_n - n0), 32'd3);
    check(wb_addr[n0 % 16] == 32'h104 && wb_beats[n0 % 16] - b0 == 2, "R8 d0 write-back after its last beat", wb_addr[n0 % 16], 32'h104);
    check(wb_addr[(n0+1) % 16] == 32'h10C && wb_beats[(n0+1) % 16] - b0 == 4, "R8 d1 write-back after its last beat", wb_addr[(n0+1) % 16], 32'h10C);
    check(wb_addr[(n0+2) % 16] == 32'h114 && wb_beats[(n0+2) % 16] - b0 == 5, "R8 d2 write-back after its last beat", wb_addr[(n0+2) % 16], 32'h114);
    check(mem[32'h10C >> 2] == mk_w1(0, 0, 1, 5), "R8 ownership cleared, rest kept", mem[32'h10C >> 2], mk_w1(0, 0, 1, 5));
    reg_read(2'd3, v); check(v == 32'h100, "R9 pointer wrapped to base", v, 32'h100);
    reg_read(2'd2, v); check(v == 32'h3 && irq, "R11 frame flag raised", v, 32'h3);
  endtask

  task automatic test_flag_clear();
    logic [31:0] v;
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); check(v[1] == 1'b1, "R11 writing 0 keeps flag", v, 32'h3);
    reg_write(2'd2, 32'h2);
    reg_read(2'd2, v); check(v[1] == 1'b0 && !irq, "R11 writing 1 clears flag", v, 32'h1);
  endtask

  task automatic test_stall_resume();
    logic [31:0] v;
    int b0, n0, idx;
    reg_write(2'd0, 32'h183);
    reg_read(2'd0, v); check(v == 32'h180, "R2 base alignment", v, 32'h180);
    reg_read(2'd3, v); check(v == 32'h180, "R2 pointer loaded while stopped", v, 32'h180);
    set_desc(32'h180, 32'h300, mk_w1(1, 0, 1, 3));
    set_desc(32'h188, 32'h310, mk_w1(0, 1, 0, 0));
    b0 = beat_cnt; n0 = wb_n;
    start_and_wait();
    check(beat_cnt - b0 == 1, "R5 three-byte buffer is one beat", 32'(beat_cnt - b0), 32'd1);
    idx = b0;
    expect_buf(idx, 32'h300, 3, 1'b1, "short");
    reg_read(2'd3, v); check(v == 32'h188, "R10 pointer stays on software entry", v, 32'h188);
    check(wb_n - n0 == 1 && mem[32'h18C >> 2] == mk_w1(0, 1, 0, 0), "R10 software entry untouched", mem[32'h18C >> 2], mk_w1(0, 1, 0, 0));
    reg_write(2'd2, 32'h2);
    set_desc(32'h188, 32'h310, mk_w1(1, 1, 0, 0));
    b0 = beat_cnt; n0 = wb_n;
    start_and_wait();
    check(beat_cnt == b0, "R5 zero length gives no beats", 32'(beat_cnt - b0), 32'd0);
    check(wb_n - n0 == 1 && wb_addr[n0 % 16] == 32'h18C, "R10 resume at stalled entry", wb_addr[n0 % 16], 32'h18C);
    check(mem[32'h18C >> 2] == mk_w1(0, 1, 0, 0), "R8 zero-length write-back", mem[32'h18C >> 2], mk_w1(0, 1, 0, 0));
    reg_read(2'd3, v); check(v == 32'h180, "R9 wrap to base 0x180", v, 32'h180);
    reg_read(2'd2, v); check(v[1] == 1'b0, "R11 no flag without end-of-frame", v, 32'h1);
  endtask

  task automatic test_backpressure();
    logic [31:0] v;
    int b0, idx;
    bp_mode = 1'b1;
    reg_write(2'd0, 32'h100);
    set_desc(32'h100, 32'h200, mk_w1(1, 0, 1, 13));
    set_desc(32'h108, 32'h240, mk_w1(1, 1, 0, 6));
    b0 = beat_cnt;
    start_and_wait();
    check(beat_cnt - b0 == 6, "R7 beats under backpressure", 32'(beat_cnt - b0), 32'd6);
    idx = b0;
    expect_buf(idx, 32'h200, 13, 1'b1, "R7 bp d0");
    expect_buf(idx, 32'h240, 6, 1'b0, "R7 bp d1");
    reg_read(2'd3, v); check(v == 32'h100, "R9 wrap after two entries", v, 32'h100);
    check(hold_viol == 0, "R12 requests held until grant", 32'(hold_viol), 32'd0);
    bp_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    test_reset();
    test_ring_wrap();
    test_flag_clear();
    test_stall_resume();
    test_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule